// File: doc/BRIEF.md
# AES Table-Round Instruction Unit

This block is a custom-instruction datapath for a small processor that runs AES-128 encryption in software using the column-table method. Each instruction supplies a function code, two 32-bit operands (`opa`, `opb`) and a start strobe. One clock later the block returns a 32-bit result together with a one-cycle done pulse. Software keeps the state and the round keys, and it runs the round loop. The block provides three kinds of help. The first is a table-word contribution for a normal round, either one table term at a time or a whole column. The second is the masked S-box byte for the last round. The third is the rotate/substitute/round-constant step of key expansion.

No table is stored anywhere. Each of the four byte lanes holds a logic S-box that inverts the input byte in GF(2^8) modulo x^8+x^4+x^3+x+1 and then applies the affine map with constant 0x63. From the substituted byte s the lane forms the base table word {2·s, s, s, 3·s}, with the first byte in bits 31:24. Doubling is xtime: shift left, then XOR 0x1B if bit 7 was set. Tripling is xtime(s) XOR s. The other three tables are byte rotations of this word. The last-round byte is taken by masking a rotated word down to its single plain-s byte.

Control is a two-state machine. In ST_IDLE the unit waits. A start strobe latches the result and moves it to ST_DONE, where done is high. From ST_DONE it returns to ST_IDLE when start is low, or stays in ST_DONE and latches a new result when start is high again.

Top module: `aes_tround_unit`

## Requirements
- R1: While rst_n is low and after its release, result is 0x00000000 and done is 0.
- R2: A start sampled at a clock edge makes done 1 for the following cycle and updates result at that edge. Without start, done is 0 in the next cycle and result keeps its value.
- R3: Function 10 returns {24'h0, S(opa[7:0])}. S is the AES S-box: the multiplicative inverse modulo 0x11B (0x00 maps to 0x00), followed by the affine map with constant 0x63. So S(0x00)=0x63 and S(0x53)=0xED.
- R4: Function k (k = 0..3) returns rotr(T(opa[7:0]), 8·k) XOR opb. Here T(b) = {2·s, s, s, 3·s}, first byte in bits 31:24, with s = S(b).
- R5: Function 4+k (k = 0..3) returns opb with S(opa[7:0]) XORed into the row-k byte, bits 31−8k down to 24−8k. All other bits equal opb.
- R6: Function 8 returns {S(opa[23:16]) XOR opb[7:0], S(opa[15:8]), S(opa[7:0]), S(opa[31:24])}.
- R7: Function 9 returns S applied to each byte of opa in place.
- R8: Function 11 returns T(opa[31:24]) XOR rotr(T(opa[23:16]),8) XOR rotr(T(opa[15:8]),16) XOR rotr(T(opa[7:0]),24) XOR opb.
- R9: Function codes 12 to 15 return 0x00000000, with the usual done pulse.
- R10: Using only functions 8, 11 and 4..7 together with software XORs, the AES-128 test key 2b7e1516 28aed2a6 abf71588 09cf4f3c expands to a last round key whose first word is d014f9a8. The same steps encrypt 3243f6a8 885a308d 313198a2 e0370734 to 3925841d 02dc09fb dc118597 196a0b32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction strobe, one cycle per operation |
| func | input | 4 | Function select code |
| opa | input | 32 | First operand, source bytes |
| opb | input | 32 | Second operand, accumulator, round key or round constant |
| result | output | 32 | Registered instruction result |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check the handshake: done follows start by exactly one cycle, and result is frozen when no start occurs. They also check that a row-0 final-round operation leaves the lower three bytes of the accumulator untouched, that unused codes give zero, and that each lane's inverse really multiplies back to one. The S-box contents, the table-word byte layout and rotations, the key-expansion byte order and the complete encryption can only be shown by the bench scenarios. The bench compares these against an S-box it builds by a different algorithm and against the known AES-128 vector.

// File: rtl/aes_ti_pkg.sv
package aes_ti_pkg;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int FUNC_W  = 4;

    localparam logic [BYTE_W-1:0] GF_REDUCE = 8'h1B;
    localparam logic [BYTE_W-1:0] AFF_CONST = 8'h63;

    localparam logic [FUNC_W-1:0] OP_TBL0 = 4'd0;
    localparam logic [FUNC_W-1:0] OP_TBL1 = 4'd1;
    localparam logic [FUNC_W-1:0] OP_TBL2 = 4'd2;
    localparam logic [FUNC_W-1:0] OP_TBL3 = 4'd3;
    localparam logic [FUNC_W-1:0] OP_FIN0 = 4'd4;
    localparam logic [FUNC_W-1:0] OP_FIN1 = 4'd5;
    localparam logic [FUNC_W-1:0] OP_FIN2 = 4'd6;
    localparam logic [FUNC_W-1:0] OP_FIN3 = 4'd7;
    localparam logic [FUNC_W-1:0] OP_KEYX = 4'd8;
    localparam logic [FUNC_W-1:0] OP_SUBW = 4'd9;
    localparam logic [FUNC_W-1:0] OP_SBOX = 4'd10;
    localparam logic [FUNC_W-1:0] OP_TCOL = 4'd11;

    typedef enum logic {ST_IDLE, ST_DONE} ti_state_e;

    function automatic logic [BYTE_W-1:0] gf_xtime(input logic [BYTE_W-1:0] a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? GF_REDUCE : '0);
    endfunction

    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    function automatic logic [WORD_W-1:0] rotr_word(input logic [WORD_W-1:0] w,
                                                    input int n);
        logic [2*WORD_W-1:0] dbl;
        dbl = {w, w} >> n;
        return dbl[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/aes_sbox_logic.sv
module aes_sbox_logic
    import aes_ti_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] sub_out
);
    logic [BYTE_W-1:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252, inv;

    // x^254 = x^-1 in GF(2^8); zero maps to zero naturally
    always_comb begin
        p2   = gf_mul(byte_in, byte_in);
        p3   = gf_mul(p2, byte_in);
        p6   = gf_mul(p3, p3);
        p12  = gf_mul(p6, p6);
        p15  = gf_mul(p12, p3);
        p30  = gf_mul(p15, p15);
        p60  = gf_mul(p30, p30);
        p120 = gf_mul(p60, p60);
        p240 = gf_mul(p120, p120);
        p252 = gf_mul(p240, p12);
        inv  = gf_mul(p252, p2);
    end

    always_comb begin
        for (int i = 0; i < BYTE_W; i++) begin
            sub_out[i] = inv[i] ^ inv[(i+4)%BYTE_W] ^ inv[(i+5)%BYTE_W]
                       ^ inv[(i+6)%BYTE_W] ^ inv[(i+7)%BYTE_W] ^ AFF_CONST[i];
        end
    end

    // R3: the inverse must multiply back to one for every nonzero input
    always_comb begin
        if (byte_in != '0) begin
            a_r3_inverse_ok: assert (gf_mul(byte_in, inv) == 8'h01);
        end
    end
endmodule

// File: rtl/aes_tword_gen.sv
module aes_tword_gen
    import aes_ti_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] tword
);
    logic [BYTE_W-1:0] s;
    logic [BYTE_W-1:0] s2;

    aes_sbox_logic u_sbox (
        .byte_in (byte_in),
        .sub_out (s)
    );

    always_comb begin
        s2    = gf_xtime(s);
        tword = {s2, s, s, s2 ^ s};
    end
endmodule

// File: rtl/aes_tround_unit.sv
module aes_tround_unit
    import aes_ti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FUNC_W-1:0] func,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic [WORD_W-1:0] result,
    output logic              done
);
    logic [WORD_W-1:0] tw   [LANES];
    logic [BYTE_W-1:0] sb   [LANES];
    logic [WORD_W-1:0] fin_w[LANES];
    logic [WORD_W-1:0] next_res;
    logic [WORD_W-1:0] result_q;
    ti_state_e         state_q, state_d;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        aes_tword_gen u_tw (
            .byte_in (opa[BYTE_W*g +: BYTE_W]),
            .tword   (tw[g])
        );
        // plain s lives in byte 2 of the base word
        assign sb[g] = tw[g][2*BYTE_W +: BYTE_W];
        // last round, row g: rotate so a plain-s byte lands on row g, mask the rest
        assign fin_w[g] = rotr_word(tw[0], BYTE_W * ((g + 2) % LANES))
                        & ({{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}}
                           << (BYTE_W * (LANES - 1 - g)));
    end

    always_comb begin
        unique case (func)
            OP_TBL0: next_res = tw[0] ^ opb;
            OP_TBL1: next_res = rotr_word(tw[0], BYTE_W)   ^ opb;
            OP_TBL2: next_res = rotr_word(tw[0], 2*BYTE_W) ^ opb;
            OP_TBL3: next_res = rotr_word(tw[0], 3*BYTE_W) ^ opb;
            OP_FIN0: next_res = fin_w[0] ^ opb;
            OP_FIN1: next_res = fin_w[1] ^ opb;
            OP_FIN2: next_res = fin_w[2] ^ opb;
            OP_FIN3: next_res = fin_w[3] ^ opb;
            OP_KEYX: next_res = {sb[2] ^ opb[BYTE_W-1:0], sb[1], sb[0], sb[3]};
            OP_SUBW: next_res = {sb[3], sb[2], sb[1], sb[0]};
            OP_SBOX: next_res = {{(WORD_W-BYTE_W){1'b0}}, sb[0]};
            OP_TCOL: next_res = tw[3]
                              ^ rotr_word(tw[2], BYTE_W)
                              ^ rotr_word(tw[1], 2*BYTE_W)
                              ^ rotr_word(tw[0], 3*BYTE_W)
                              ^ opb;
            default: next_res = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (start) result_q <= next_res;
        end
    end

    always_comb begin
        done   = (state_q == ST_DONE);
        result = result_q;
    end

    a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));
    a_r5_fin_row0_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (start && func == OP_FIN0) |=> (((result ^ $past(opb)) & 32'h00FF_FFFF) == '0));
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && func >= 4'd12) |=> (result == '0));
endmodule

// File: tb/tb_aes_tround_unit.sv
module tb_aes_tround_unit;
    import aes_ti_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  func = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] ref_s [256];

    always #2 clk = ~clk;

    aes_tround_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .opa(opa), .opb(opb), .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bx2(input logic [7:0] a);
        return (a << 1) ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] rl8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    // reference S-box by the 3-generator walk, independent of the design's method
    task automatic build_ref();
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ (p << 1) ^ (p[7] ? 8'h1B : 8'h00);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            x = q ^ rl8(q, 1) ^ rl8(q, 2) ^ rl8(q, 3) ^ rl8(q, 4);
            ref_s[p] = x ^ 8'h63;
        end while (p != 8'h01);
        ref_s[0] = 8'h63;
    endtask

    function automatic logic [31:0] ref_t(input logic [7:0] b);
        logic [7:0] s;
        s = ref_s[b];
        return {bx2(s), s, s, bx2(s) ^ s};
    endfunction

    function automatic logic [31:0] rr(input logic [31:0] w, input int n);
        return (n == 0) ? w : ((w >> n) | (w << (32 - n)));
    endfunction

    task automatic op(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                      output logic [31:0] r);
        @(negedge clk);
        start = 1'b1; func = f; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        r = result;
        chk(done === 1'b1, "R2 done pulse", {31'b0, done}, 32'h1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(result === 32'h0 && done === 1'b0, "R1 in reset", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result === 32'h0 && done === 1'b0, "R1 after reset", result, 32'h0);
    endtask

    task automatic t_sbox_all();
        logic [31:0] r;
        for (int i = 0; i < 256; i++) begin
            op(OP_SBOX, {24'hABCDEF, 8'(i)}, 32'hFFFF_FFFF, r);
            chk(r === {24'h0, ref_s[i]}, "R3 sbox", r, {24'h0, ref_s[i]});
        end
        op(OP_SBOX, 32'h53, 32'h0, r);
        chk(r === 32'hED, "R3 S(53)", r, 32'hED);
        op(OP_SBOX, 32'h00, 32'h0, r);
        chk(r === 32'h63, "R3 S(00)", r, 32'h63);
    endtask

    task automatic t_hold();
        logic [31:0] r;
        op(OP_SBOX, 32'h53, 32'h0, r);
        repeat (3) @(negedge clk);
        chk(result === 32'hED && done === 1'b0, "R2 hold without start", result, 32'hED);
    endtask

    task automatic t_tbl();
        logic [31:0] r, e;
        logic [7:0] bs [4] = '{8'h00, 8'h80, 8'hD4, 8'h53};
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 4; j++) begin
                e = rr(ref_t(bs[j]), 8 * k) ^ 32'h1234_5678;
                op(4'(k), {24'h0, bs[j]}, 32'h1234_5678, r);
                chk(r === e, "R4 table word", r, e);
            end
        end
    endtask

    task automatic t_fin();
        logic [31:0] r, e;
        for (int k = 0; k < 4; k++) begin
            e = 32'hA5A5_3C3C ^ ({24'h0, ref_s[8'h6E]} << (8 * (3 - k)));
            op(4'(4 + k), 32'h6E, 32'hA5A5_3C3C, r);
            chk(r === e, "R5 final byte", r, e);
        end
    endtask

    task automatic t_key_subw();
        logic [31:0] r, e;
        logic [31:0] w = 32'h09CF_4F3C;
        e = {ref_s[w[23:16]] ^ 8'h01, ref_s[w[15:8]], ref_s[w[7:0]], ref_s[w[31:24]]};
        op(OP_KEYX, w, 32'hFFFF_FF01, r);
        chk(r === e, "R6 key step", r, e);
        e = {ref_s[w[31:24]], ref_s[w[23:16]], ref_s[w[15:8]], ref_s[w[7:0]]};
        op(OP_SUBW, w, 32'h0, r);
        chk(r === e, "R7 subword", r, e);
    endtask

    task automatic t_tcol_unused();
        logic [31:0] r, e;
        logic [31:0] a = 32'hD4BF_5D30;
        e = ref_t(a[31:24]) ^ rr(ref_t(a[23:16]), 8) ^ rr(ref_t(a[15:8]), 16)
          ^ rr(ref_t(a[7:0]), 24) ^ 32'h0F0F_0F0F;
        op(OP_TCOL, a, 32'h0F0F_0F0F, r);
        chk(r === e, "R8 column", r, e);
        op(4'd12, a, 32'hFFFF_FFFF, r);
        chk(r === 32'h0, "R9 code 12", r, 32'h0);
        op(4'd15, a, 32'hFFFF_FFFF, r);
        chk(r === 32'h0, "R9 code 15", r, 32'h0);
    endtask

    task automatic t_encrypt();
        logic [31:0] w [44];
        logic [31:0] c [4];
        logic [31:0] n [4];
        logic [31:0] t, acc;
        logic [7:0]  rc;
        logic [31:0] pt [4] = '{32'h3243f6a8, 32'h885a308d, 32'h313198a2, 32'he0370734};
        logic [31:0] ct [4] = '{32'h3925841d, 32'h02dc09fb, 32'hdc118597, 32'h196a0b32};
        w[0] = 32'h2b7e1516; w[1] = 32'h28aed2a6; w[2] = 32'habf71588; w[3] = 32'h09cf4f3c;
        rc = 8'h01;
        for (int i = 4; i < 44; i++) begin
            if (i % 4 == 0) begin
                op(OP_KEYX, w[i-1], {24'h0, rc}, t);
                rc = bx2(rc);
                w[i] = w[i-4] ^ t;
            end else begin
                w[i] = w[i-4] ^ w[i-1];
            end
        end
        chk(w[40] === 32'hd014f9a8, "R10 last round key", w[40], 32'hd014f9a8);
        for (int j = 0; j < 4; j++) c[j] = pt[j] ^ w[j];
        for (int rnd = 1; rnd < 10; rnd++) begin
            for (int j = 0; j < 4; j++) begin
                op(OP_TCOL, {c[j][31:24], c[(j+1)%4][23:16], c[(j+2)%4][15:8], c[(j+3)%4][7:0]},
                   w[4*rnd + j], n[j]);
            end
            for (int j = 0; j < 4; j++) c[j] = n[j];
        end
        for (int j = 0; j < 4; j++) begin
            acc = w[40 + j];
            for (int r = 0; r < 4; r++) begin
                op(4'(4 + r), {24'h0, c[(j+r)%4][31-8*r -: 8]}, acc, acc);
            end
            n[j] = acc;
        end
        for (int j = 0; j < 4; j++) chk(n[j] === ct[j], "R10 ciphertext", n[j], ct[j]);
    endtask

    initial begin
        fork
            begin
                build_ref();
                t_reset();
                t_sbox_all();
                t_hold();
                t_tbl();
                t_fin();
                t_key_subw();
                t_tcol_unused();
                t_encrypt();
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog expired", 32'h0, 32'h1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule